// File: doc/BRIEF.md
# Rectangular 2D Block-Transfer Engine

This block moves or fills rectangles of pixels in a byte-addressed frame-buffer memory. A host CPU sets up the job through byte-wide configuration registers: source start, destination start, width, height, line pitch, operation code, pixel depth and fill colour. It then sets a start bit. That same bit reads back as a busy flag until the job ends. When the bit drops, a one-cycle completion pulse is also raised.

Two operations are supported. A move copies a source rectangle onto a destination rectangle, one pixel at a time, reading each pixel before writing it. It can run forward, starting at the top-left pixel with addresses rising, or backward, starting at the bottom-right pixel with addresses falling. Software chooses the direction so that overlapping copies come out right. A fill writes the foreground colour to every pixel of the destination rectangle. Pixels are 8 or 16 bits wide. The memory port makes one pixel access per cycle, and each access is held until the memory raises ready.

Top module: `blt_engine`

## Requirements
- R1: Register offsets are as follows.
  - 0x00: control; bit 7 is start/busy.
  - 0x01: depth; bit 0 set means 16 bpp, clear means 8 bpp, and the other bits read 0.
  - 0x02: opcode.
  - 0x04-0x06: source bytes, low to high.
  - 0x08-0x0A: destination bytes, low to high.
  - 0x0C/0x0D: width low/high.
  - 0x0E/0x0F: height low/high.
  - 0x10/0x11: pitch low/high.
  - 0x12/0x13: colour low/high.
  
  Every configuration register reads back the value written, one cycle after the address is presented.
- R2: Writing a value with bit 7 set to offset 0x00 while idle starts the job. Bit 7 of offset 0x00 reads 1 until the job ends, and then reads 0.
- R3: `done_pulse` is high for exactly one cycle, in the first cycle in which busy is low after a job.
- R4: Opcode 0x02 is a forward move. Width and height registers hold the pixel count minus one. The pixel at (x, y) of the rectangle lies at start + y·pitch_bytes + x·pixel_bytes.
- R5: Opcode 0x03 is a backward move. The start addresses name the bottom-right pixel. The pixel at offset (x, y) from it lies at start − y·pitch_bytes − x·pixel_bytes.
- R6: An overlapping move with the direction chosen by the rule (backward when the destination row is lower, or the rows are equal and the destination column is at or right of the source column) leaves the destination equal to the original source contents.
- R7: Opcode 0x0C fills the destination rectangle with the colour. In 8 bpp mode only the colour's low byte is written, and no byte outside the rectangle changes.
- R8: In 16 bpp mode each access is a 2-byte little-endian pixel (`mem_wide`=1) and addresses step by 2. In 8 bpp mode accesses are single bytes and addresses step by 1.
- R9: The pitch is a count of 16-bit words; one row step is 2 × pitch bytes.
- R10: A move reads each source pixel before writing its destination pixel. A request holds its address and direction until `mem_ready`. A move makes exactly 2·W·H accesses and a fill makes W·H accesses.
- R11: Register writes, including a second start, are ignored while busy.
- R12: Any other opcode completes without any memory access.
- R13: After reset the engine is idle, all registers read 0, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 16-bit pixel access, 0 = byte access |
| mem_addr | output | 24 | Byte address of the pixel |
| mem_wdata | output | 16 | Write pixel data |
| mem_rdata | input | 16 | Read pixel data, little-endian |
| mem_ready | input | 1 | Access completes in this cycle |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
A corrupted row or column counter shows up as a wrong number of memory accesses. It also shows up as bytes written just outside the rectangle, which a full comparison of the frame buffer after each job catches. A wrong step or pitch sign turns an overlapping move into smeared data, visible in the first destination row that overlaps the source. A stuck control state leaves the busy bit set, which the polling loop notices after a bounded number of reads. Requests that drop or shift before ready are flagged in the cycle after the stall.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam int ADDR_W = 24;
  localparam int DIM_W  = 16;
  localparam int RA_W   = 5;

  localparam int RA_CTL  = 0;
  localparam int RA_DEP  = 1;
  localparam int RA_OPC  = 2;
  localparam int RA_SRC0 = 4;
  localparam int RA_SRC1 = 5;
  localparam int RA_SRC2 = 6;
  localparam int RA_DST0 = 8;
  localparam int RA_DST1 = 9;
  localparam int RA_DST2 = 10;
  localparam int RA_WID0 = 12;
  localparam int RA_WID1 = 13;
  localparam int RA_HGT0 = 14;
  localparam int RA_HGT1 = 15;
  localparam int RA_PIT0 = 16;
  localparam int RA_PIT1 = 17;
  localparam int RA_FG0  = 18;
  localparam int RA_FG1  = 19;

  localparam logic [7:0] OP_MOVE_FWD  = 8'h02;
  localparam logic [7:0] OP_MOVE_BACK = 8'h03;
  localparam logic [7:0] OP_FILL      = 8'h0C;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [DIM_W-1:0]  wid;
    logic [DIM_W-1:0]  hgt;
    logic [DIM_W-1:0]  pitch;
    logic [15:0]       fg;
    logic [7:0]        opc;
    logic              d16;
  } cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} blt_state_t;
endpackage

// File: rtl/blt_regs.sv
module blt_regs
  import blt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [RA_W-1:0] addr,
  input  logic [7:0]      wdata,
  input  logic            busy,
  output cfg_t            cfg,
  output logic            start,
  output logic [7:0]      rdata
);
  logic [7:0] rd_mux;

  assign start = wr && !busy && (addr == RA_W'(RA_CTL)) && wdata[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr && !busy) begin
      case (addr)
        RA_W'(RA_DEP):  cfg.d16          <= wdata[0];
        RA_W'(RA_OPC):  cfg.opc          <= wdata;
        RA_W'(RA_SRC0): cfg.src[7:0]     <= wdata;
        RA_W'(RA_SRC1): cfg.src[15:8]    <= wdata;
        RA_W'(RA_SRC2): cfg.src[23:16]   <= wdata;
        RA_W'(RA_DST0): cfg.dst[7:0]     <= wdata;
        RA_W'(RA_DST1): cfg.dst[15:8]    <= wdata;
        RA_W'(RA_DST2): cfg.dst[23:16]   <= wdata;
        RA_W'(RA_WID0): cfg.wid[7:0]     <= wdata;
        RA_W'(RA_WID1): cfg.wid[15:8]    <= wdata;
        RA_W'(RA_HGT0): cfg.hgt[7:0]     <= wdata;
        RA_W'(RA_HGT1): cfg.hgt[15:8]    <= wdata;
        RA_W'(RA_PIT0): cfg.pitch[7:0]   <= wdata;
        RA_W'(RA_PIT1): cfg.pitch[15:8]  <= wdata;
        RA_W'(RA_FG0):  cfg.fg[7:0]      <= wdata;
        RA_W'(RA_FG1):  cfg.fg[15:8]     <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_W'(RA_CTL):  rd_mux = {busy, 7'b0};
      RA_W'(RA_DEP):  rd_mux = {7'b0, cfg.d16};
      RA_W'(RA_OPC):  rd_mux = cfg.opc;
      RA_W'(RA_SRC0): rd_mux = cfg.src[7:0];
      RA_W'(RA_SRC1): rd_mux = cfg.src[15:8];
      RA_W'(RA_SRC2): rd_mux = cfg.src[23:16];
      RA_W'(RA_DST0): rd_mux = cfg.dst[7:0];
      RA_W'(RA_DST1): rd_mux = cfg.dst[15:8];
      RA_W'(RA_DST2): rd_mux = cfg.dst[23:16];
      RA_W'(RA_WID0): rd_mux = cfg.wid[7:0];
      RA_W'(RA_WID1): rd_mux = cfg.wid[15:8];
      RA_W'(RA_HGT0): rd_mux = cfg.hgt[7:0];
      RA_W'(RA_HGT1): rd_mux = cfg.hgt[15:8];
      RA_W'(RA_PIT0): rd_mux = cfg.pitch[7:0];
      RA_W'(RA_PIT1): rd_mux = cfg.pitch[15:8];
      RA_W'(RA_FG0):  rd_mux = cfg.fg[7:0];
      RA_W'(RA_FG1):  rd_mux = cfg.fg[15:8];
      default:        rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/blt_walker.sv
module blt_walker
  import blt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [DIM_W-1:0]  wid,
  input  logic [DIM_W-1:0]  hgt,
  input  logic [DIM_W-1:0]  pitch,
  input  logic              d16,
  input  logic              back,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              last
);
  logic [ADDR_W-1:0] src_row, dst_row;
  logic [DIM_W-1:0]  x_cnt, y_cnt;
  logic [ADDR_W-1:0] step, row_step;
  logic [ADDR_W-1:0] src_nrow, dst_nrow, src_npix, dst_npix;
  logic              row_end;

  assign step     = d16 ? ADDR_W'(2) : ADDR_W'(1);
  assign row_step = ADDR_W'({pitch, 1'b0});
  assign row_end  = (x_cnt == wid);
  assign last     = row_end && (y_cnt == hgt);

  assign src_nrow = back ? src_row - row_step : src_row + row_step;
  assign dst_nrow = back ? dst_row - row_step : dst_row + row_step;
  assign src_npix = back ? src_addr - step : src_addr + step;
  assign dst_npix = back ? dst_addr - step : dst_addr + step;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_row <= '0; dst_row <= '0; src_addr <= '0; dst_addr <= '0;
      x_cnt <= '0; y_cnt <= '0;
    end else if (load) begin
      src_row <= src_base; src_addr <= src_base;
      dst_row <= dst_base; dst_addr <= dst_base;
      x_cnt <= '0; y_cnt <= '0;
    end else if (adv) begin
      if (row_end) begin
        x_cnt    <= '0;
        y_cnt    <= y_cnt + 1'b1;
        src_row  <= src_nrow; src_addr <= src_nrow;
        dst_row  <= dst_nrow; dst_addr <= dst_nrow;
      end else begin
        x_cnt    <= x_cnt + 1'b1;
        src_addr <= src_npix;
        dst_addr <= dst_npix;
      end
    end
  end
endmodule

// File: rtl/blt_ctrl.sv
module blt_ctrl
  import blt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  opc,
  input  logic        last,
  input  logic        mem_ready,
  input  logic [15:0] mem_rdata,
  output logic        busy,
  output logic        done_pulse,
  output logic        mem_req,
  output logic        mem_we,
  output logic        adv,
  output logic [15:0] rbuf
);
  blt_state_t state;
  logic       is_move;

  assign is_move = (opc == OP_MOVE_FWD) || (opc == OP_MOVE_BACK);
  assign mem_req = (state == S_RD) || (state == S_WR);
  assign mem_we  = (state == S_WR);
  assign adv     = (state == S_WR) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      busy       <= 1'b0;
      done_pulse <= 1'b0;
      rbuf       <= '0;
    end else begin
      done_pulse <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          busy <= 1'b1;
          if (is_move)              state <= S_RD;
          else if (opc == OP_FILL)  state <= S_WR;
          else                      state <= S_FIN;
        end
        S_RD: if (mem_ready) begin
          rbuf  <= mem_rdata;
          state <= S_WR;
        end
        S_WR: if (mem_ready) begin
          if (last)         state <= S_FIN;
          else if (is_move) state <= S_RD;
          else              state <= S_WR;
        end
        default: begin
          busy       <= 1'b0;
          done_pulse <= 1'b1;
          state      <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/blt_engine.sv
module blt_engine
  import blt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              done_pulse
);
  cfg_t              cfg;
  logic              busy, start, adv, last;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [15:0]       rbuf, pix;

  blt_regs u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .cfg(cfg), .start(start), .rdata(reg_rdata)
  );

  blt_walker u_walk (
    .clk(clk), .rst(rst), .load(start), .adv(adv),
    .src_base(cfg.src), .dst_base(cfg.dst), .wid(cfg.wid), .hgt(cfg.hgt),
    .pitch(cfg.pitch), .d16(cfg.d16), .back(cfg.opc == OP_MOVE_BACK),
    .src_addr(src_addr), .dst_addr(dst_addr), .last(last)
  );

  blt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .opc(cfg.opc), .last(last),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy),
    .done_pulse(done_pulse), .mem_req(mem_req), .mem_we(mem_we),
    .adv(adv), .rbuf(rbuf)
  );

  assign pix       = (cfg.opc == OP_FILL) ? cfg.fg : rbuf;
  assign mem_wdata = cfg.d16 ? pix : {8'h00, pix[7:0]};
  assign mem_addr  = mem_we ? dst_addr : src_addr;
  assign mem_wide  = cfg.d16;
endmodule

// File: rtl/blt_engine_chk.sv
module blt_engine_chk
  import blt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done_pulse,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_wide,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input cfg_t              cfg
);
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (!busy && $past(busy))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse); // R3
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R12
  AST_HOLD_TO_READY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(cfg)); // R11
  AST_WIDE_DEPTH: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_wide == cfg.d16)); // R8
endmodule

bind blt_engine blt_engine_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done_pulse(done_pulse),
  .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
  .mem_addr(mem_addr), .mem_ready(mem_ready), .cfg(cfg)
);

// File: tb/blt_engine_tb.sv
module blt_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_req, mem_we, mem_wide, done_pulse;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_ready;

  logic [7:0] mem  [0:1023];
  logic [7:0] expm [0:1023];
  logic [7:0] snap [0:1023];
  logic       stall_mode = 1'b0;
  logic [1:0] rcnt = '0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  int done_cnt = 0, acc_cnt = 0, order_err = 0;
  logic cur_move = 1'b0, last_rd = 1'b0;

  always #2 clk = ~clk;

  blt_engine u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done_pulse(done_pulse)
  );

  assign mem_ready = !stall_mode || (rcnt == 2'd3);
  assign mem_rdata = {mem[(mem_addr[9:0] + 10'd1)], mem[mem_addr[9:0]]};

  always @(posedge clk) begin
    rcnt <= rcnt + 2'd1;
    if (done_pulse) done_cnt <= done_cnt + 1;
    if (mem_req && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (cur_move && mem_we && !last_rd) order_err <= order_err + 1;
      last_rd <= !mem_we;
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata[7:0];
        if (mem_wide) mem[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (R2): actual still running, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 5'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 5'(a); reg_wr = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic compare_mem(input string tag);
    int bad = -1;
    for (int i = 0; i < 1024; i++)
      if (bad < 0 && mem[i] !== expm[i]) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, {tag, " mem byte"}, int'(mem[bad]), int'(expm[bad]));
  endtask

  task automatic run_op(input int op, input int src, input int dst, input int wm1,
                        input int hm1, input int pitch, input bit d16, input int fg,
                        input bit mid_writes, input string tag);
    logic [7:0] v;
    int pb, st, s, d, off, guard, a0, a1;
    bit busy_seen;
    pb = 2 * pitch; st = d16 ? 2 : 1;
    for (int i = 0; i < 1024; i++) begin expm[i] = mem[i]; snap[i] = mem[i]; end
    for (int y = 0; y <= hm1; y++)
      for (int x = 0; x <= wm1; x++) begin
        off = y * pb + x * st;
        s = (op == 3) ? src - off : src + off;
        d = (op == 3) ? dst - off : dst + off;
        if (op == 12) begin
          expm[d & 1023] = 8'(fg);
          if (d16) expm[(d + 1) & 1023] = 8'(fg >> 8);
        end else if (op == 2 || op == 3) begin
          expm[d & 1023] = snap[s & 1023];
          if (d16) expm[(d + 1) & 1023] = snap[(s + 1) & 1023];
        end
      end
    wr(1, d16); wr(2, op);
    wr(4, src); wr(5, src >> 8); wr(6, src >> 16);
    wr(8, dst); wr(9, dst >> 8); wr(10, dst >> 16);
    wr(12, wm1); wr(13, wm1 >> 8); wr(14, hm1); wr(15, hm1 >> 8);
    wr(16, pitch); wr(17, pitch >> 8); wr(18, fg); wr(19, fg >> 8);
    cur_move = (op == 2 || op == 3);
    last_rd = 1'b0;
    a0 = acc_cnt; a1 = done_cnt;
    wr(0, 8'h80);
    if (mid_writes) begin
      wr(18, 8'h11); wr(8, 8'h99); wr(0, 8'h80);
    end
    busy_seen = 1'b0; guard = 0;
    do begin
      rd(0, v);
      if (v[7]) busy_seen = 1'b1;
      guard++;
    end while (v[7] && guard < 20000);
    check(!v[7], {tag, " R2 busy clears"}, int'(v), 0);
    if (op == 2 || op == 3 || op == 12)
      check(busy_seen, {tag, " R2 busy seen"}, int'(busy_seen), 1);
    check(done_cnt - a1 == 1, {tag, " R3 done pulses"}, done_cnt - a1, 1);
    if (op == 2 || op == 3)
      check(acc_cnt - a0 == 2 * (wm1 + 1) * (hm1 + 1), {tag, " R10 access count"},
            acc_cnt - a0, 2 * (wm1 + 1) * (hm1 + 1));
    else if (op == 12)
      check(acc_cnt - a0 == (wm1 + 1) * (hm1 + 1), {tag, " R10 access count"},
            acc_cnt - a0, (wm1 + 1) * (hm1 + 1));
    else
      check(acc_cnt - a0 == 0, {tag, " R12 no access"}, acc_cnt - a0, 0);
    compare_mem(tag);
    if (mid_writes) begin
      rd(18, v); check(v == 8'(fg), "R11 colour kept", int'(v), fg & 255);
      rd(8, v);  check(v == 8'(dst), "R11 dest kept", int'(v), dst & 255);
    end
    cur_move = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v);  check(v == 0, "R13 ctl after reset", int'(v), 0);
    rd(18, v); check(v == 0, "R13 colour after reset", int'(v), 0);
    check(!mem_req && !done_pulse, "R13 idle port", int'(mem_req), 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(6, 8'h5A);  rd(6, v);  check(v == 8'h5A, "R1 src high byte", int'(v), 'h5A);
    wr(17, 8'h3C); rd(17, v); check(v == 8'h3C, "R1 pitch high byte", int'(v), 'h3C);
    wr(1, 8'hFF);  rd(1, v);  check(v == 8'h01, "R1 depth reg", int'(v), 1);
    wr(13, 8'h00); rd(13, v); check(v == 8'h00, "R1 width high", int'(v), 0);
    wr(17, 0); wr(6, 0);
  endtask

  task automatic t_fwd8;
    stall_mode = 1'b1;
    run_op(2, 'h010, 'h200, 4, 2, 8, 1'b0, 0, 1'b0, "R4 R8 R9 fwd8");
    check(order_err == 0, "R10 read before write", order_err, 0);
    stall_mode = 1'b0;
  endtask

  task automatic t_fwd16;
    run_op(2, 'h040, 'h280, 3, 3, 16, 1'b1, 0, 1'b0, "R8 fwd16");
  endtask

  task automatic t_back_overlap;
    int base = 'h300, pb = 32, w = 4, h = 3;
    int s = base + (1 + h - 1) * pb + 2 * (2 + w - 1);
    int d = base + (2 + h - 1) * pb + 2 * (3 + w - 1);
    run_op(3, s, d, w - 1, h - 1, 16, 1'b1, 0, 1'b0, "R5 R6 backward overlap");
  endtask

  task automatic t_fwd_overlap;
    run_op(2, 'h080 + 32 + 3, 'h080 + 1, 5, 2, 16, 1'b0, 0, 1'b0, "R6 forward overlap");
  endtask

  task automatic t_fill;
    run_op(12, 'h000, 'h100, 6, 1, 4, 1'b0, 'hA55A, 1'b0, "R7 fill8");
    stall_mode = 1'b1;
    run_op(12, 'h000, 'h180, 2, 2, 8, 1'b1, 'hBEEF, 1'b0, "R7 fill16");
    stall_mode = 1'b0;
  endtask

  task automatic t_busy_ignore;
    stall_mode = 1'b1;
    run_op(12, 'h000, 'h3A0, 7, 2, 16, 1'b1, 'h1234, 1'b1, "R11 busy writes");
    stall_mode = 1'b0;
  endtask

  task automatic t_badop;
    run_op(7, 'h010, 'h020, 3, 3, 8, 1'b0, 0, 1'b0, "R12 bad opcode");
  endtask

  task automatic t_single;
    run_op(2, 'h3F0, 'h050, 0, 0, 1, 1'b0, 0, 1'b0, "R4 single pixel");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_fwd8();
    t_fwd16();
    t_back_overlap();
    t_fwd_overlap();
    t_fill();
    t_busy_ignore();
    t_badop();
    t_single();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule